// File: doc/BRIEF.md
# Serial Line Break and Idle Detector

This block watches a single asynchronous serial receive line that is oversampled by the system clock. It reports two line conditions that a character receiver cannot see on its own. A break is a low level that lasts at least one whole frame time. An idle frame is a high level that lasts one whole frame time.

The frame time is worked out from the character format and the bit period. The format is given by the number of data bits, a parity flag and the number of stop bits. The bit period is a whole number of clock cycles plus a fraction in sixteenths. An optional inversion lets the block serve lines whose idle level is low.

A break is reported only when the low period ends. It produces one-cycle pulses on `break_pulse` and on `rx_restart`, which tells the neighbouring receiver to return to its hunt-for-start state. Idle pulses repeat once per frame time for as long as the line stays high. Character assembly, parity checking and baud generation are left to other blocks.

Top module: `uart_line_watch`

## Requirements
- R1: The frame length F in clock cycles is (1 + data bits + 1 if parity is enabled + stop bits) multiplied by (cycles-per-bit + fraction/16), rounded up to a whole cycle. For example, 8 data bits, parity enabled, 2 stop bits and 3 + 1/16 cycles per bit give F = 37.
- R2: When the line has been sampled low for N consecutive cycles, with N >= F, a one-cycle `break_pulse` is raised 3 cycles after the line input returns high.
- R3: A low period of F-1 sampled cycles or fewer raises no `break_pulse`.
- R4: Every falling edge restarts the low-period measurement. Two low periods that are each shorter than F and are separated by a short high level raise no break.
- R5: `rx_restart` pulses in the same cycle as `break_pulse`, and at no other time.
- R6: After the line input rises, the first `idle_pulse` is raised F+3 cycles later. While the line stays high, a further pulse follows every F cycles.
- R7: A single low sample cancels any idle period in progress. Idle timing starts again from the next rise.
- R8: With `cfg_invert` = 1, the line is complemented before any edge, break or idle evaluation.
- R9: The format inputs and bit-period inputs are captured only while the synchronized line is high. A change made during a low period does not alter the break threshold for that period.
- R10: The low-period counter saturates instead of wrapping, so a low period longer than the counter range still raises a break.
- R11: While reset is asserted, and right after it is released, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial line |
| cfg_invert | input | 1 | 1 = complement the line before evaluation |
| cfg_data_bits | input | 4 | Data bits per character |
| cfg_parity_en | input | 1 | 1 = the frame carries a parity bit |
| cfg_stop_bits | input | 2 | Stop bits per character |
| cfg_cpb | input | CPB_W | Whole clock cycles per bit |
| cfg_cpb_frac | input | FRAC_W | Fraction of a cycle per bit, in 1/2^FRAC_W steps |
| break_pulse | output | 1 | One-cycle pulse when a break ends |
| idle_pulse | output | 1 | One-cycle pulse for each idle frame time |
| rx_restart | output | 1 | One-cycle request to reset the companion receiver |

## Verification
The line passes through two synchronizer flops and then an edge register, and each output is registered. A break is therefore due exactly 3 cycles after the input rises, and the first idle pulse F+3 cycles after it. The bench drives and samples on the falling clock edge. It counts falling edges from each stimulus change and checks every output at the exact cycle it is due, and also in the cycles on either side where it must stay low. For idle timing, the bench records the position of each pulse in a window and compares those positions with F+3 and 2F+3. Thresholds are checked at F and at F-1 for two different frame formats, one of which includes a fractional bit period that needs rounding up.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;

  typedef struct packed {
    logic [3:0] data_bits;
    logic       parity_en;
    logic [1:0] stop_bits;
  } frame_fmt_t;

  // Bit times in one frame: start + data + optional parity + stop.
  function automatic logic [4:0] frame_bit_count(input frame_fmt_t f);
    frame_bit_count = 5'd1 + {1'b0, f.data_bits} + {4'b0, f.parity_en}
                      + {3'b0, f.stop_bits};
  endfunction

endpackage

// File: rtl/lc_line_sync.sv
module lc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic invert,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              lvl_q;

  // Inversion is applied ahead of the chain so that every later stage sees a
  // line whose idle level is high.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= line_in ^ invert;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b1;
    else     lvl_q <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/lc_frame_len.sv
module lc_frame_len
  import uart_lc_pkg::*;
#(
  parameter int CPB_W  = 16,
  parameter int FRAC_W = 4,
  localparam int FL_W  = CPB_W + 5,
  localparam int PW    = 5 + CPB_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  frame_fmt_t        fmt,
  input  logic [CPB_W-1:0]  cpb,
  input  logic [FRAC_W-1:0] cpb_frac,
  output logic [FL_W-1:0]   flen_q
);
  logic [4:0]      nbits;
  logic [PW-1:0]   prod;
  logic [FL_W-1:0] whole;
  logic            has_frac;

  always_comb begin
    nbits    = frame_bit_count(fmt);
    prod     = PW'(nbits) * PW'({cpb, cpb_frac});
    whole    = prod[PW-1:FRAC_W];
    has_frac = |prod[FRAC_W-1:0];
  end

  // Capture only while the line is high, so a threshold never moves under a
  // low period that is being measured.
  always_ff @(posedge clk) begin
    if (rst || load) flen_q <= whole + FL_W'(has_frac);
  end

  AST_CFG_HELD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(flen_q)); // R9

endmodule

// File: rtl/lc_low_track.sv
module lc_low_track #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] flen,
  output logic             brk_o,
  output logic             restart_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] low_cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      armed     <= 1'b0;
      brk_o     <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      brk_o     <= 1'b0;
      restart_o <= 1'b0;
      if (fall) begin
        low_cnt <= CNT_W'(1);
        armed   <= 1'b1;
      end else if (!lvl) begin
        if (low_cnt != CMAX) low_cnt <= low_cnt + CNT_W'(1);
      end else if (rise) begin
        if (armed && (low_cnt >= flen)) begin
          brk_o     <= 1'b1;
          restart_o <= 1'b1;
        end
        armed <= 1'b0;
      end
    end
  end

  AST_LOW_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (low_cnt == CMAX) && !lvl && !fall |=> (low_cnt == CMAX)); // R10
  AST_BREAK_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> $past(rise)); // R2
  AST_BREAK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    brk_o |=> !brk_o); // R2

endmodule

// File: rtl/lc_high_track.sv
module lc_high_track #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic [CNT_W-1:0] flen,
  output logic             idle_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] high_cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (rst) begin
      high_cnt <= '0;
      running  <= 1'b0;
      idle_o   <= 1'b0;
    end else begin
      idle_o <= 1'b0;
      if (!lvl) begin
        running <= 1'b0;
      end else if (!running) begin
        running  <= 1'b1;
        high_cnt <= CNT_W'(1);
      end else if (high_cnt >= flen) begin
        idle_o   <= 1'b1;
        high_cnt <= CNT_W'(1);
      end else if (high_cnt != CMAX) begin
        high_cnt <= high_cnt + CNT_W'(1);
      end
    end
  end

  AST_NO_IDLE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    !lvl |=> !idle_o); // R7

endmodule

// File: rtl/uart_line_watch.sv
module uart_line_watch
  import uart_lc_pkg::*;
#(
  parameter int CPB_W       = 16,
  parameter int FRAC_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = CPB_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              cfg_invert,
  input  logic [3:0]        cfg_data_bits,
  input  logic              cfg_parity_en,
  input  logic [1:0]        cfg_stop_bits,
  input  logic [CPB_W-1:0]  cfg_cpb,
  input  logic [FRAC_W-1:0] cfg_cpb_frac,
  output logic              break_pulse,
  output logic              idle_pulse,
  output logic              rx_restart
);
  frame_fmt_t       fmt;
  logic             lvl, rise, fall;
  logic [CNT_W-1:0] flen;

  assign fmt = '{data_bits: cfg_data_bits, parity_en: cfg_parity_en,
                 stop_bits: cfg_stop_bits};

  lc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(rx_line), .invert(cfg_invert),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  lc_frame_len #(.CPB_W(CPB_W), .FRAC_W(FRAC_W)) u_flen (
    .clk(clk), .rst(rst), .load(lvl), .fmt(fmt), .cpb(cfg_cpb),
    .cpb_frac(cfg_cpb_frac), .flen_q(flen)
  );

  lc_low_track #(.CNT_W(CNT_W)) u_low (
    .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .fall(fall), .flen(flen),
    .brk_o(break_pulse), .restart_o(rx_restart)
  );

  lc_high_track #(.CNT_W(CNT_W)) u_high (
    .clk(clk), .rst(rst), .lvl(lvl), .flen(flen), .idle_o(idle_pulse)
  );

  AST_NO_BREAK_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    !lvl |=> !break_pulse); // R2
  AST_RESTART_MATCHES_BREAK: assert property (@(posedge clk) disable iff (rst)
    rx_restart |-> break_pulse); // R5

endmodule

// File: tb/uart_line_watch_test.sv
`timescale 1ns/1ps
module uart_line_watch_test;
  localparam int CPB_W  = 8;
  localparam int FRAC_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic cfg_invert = 1'b0;
  logic [3:0] cfg_data_bits = 4'd8;
  logic cfg_parity_en = 1'b0;
  logic [1:0] cfg_stop_bits = 2'd1;
  logic [CPB_W-1:0] cfg_cpb = 8'd4;
  logic [FRAC_W-1:0] cfg_cpb_frac = '0;
  logic break_pulse, idle_pulse, rx_restart;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_line_watch #(.CPB_W(CPB_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .cfg_invert(cfg_invert),
    .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_stop_bits(cfg_stop_bits), .cfg_cpb(cfg_cpb),
    .cfg_cpb_frac(cfg_cpb_frac), .break_pulse(break_pulse),
    .idle_pulse(idle_pulse), .rx_restart(rx_restart)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fmt(input int d, input int p, input int s, input int c, input int f);
    cfg_data_bits = 4'(d); cfg_parity_en = 1'(p); cfg_stop_bits = 2'(s);
    cfg_cpb = CPB_W'(c); cfg_cpb_frac = FRAC_W'(f);
    step(6);
  endtask

  // Drive low for len sampled cycles, release, and check the break window.
  task automatic low_then_check(input int len, input int exp, input string tag);
    rx_line = 1'b0;
    step(len);
    rx_line = 1'b1;
    step(1); chk(break_pulse, 0, {tag, " early1"});
    step(1); chk(break_pulse, 0, {tag, " early2"});
    step(1); chk(break_pulse, exp, {tag, " due"});
             chk(rx_restart, exp, "R5 restart with break");
    step(1); chk(break_pulse, 0, {tag, " after"});
             chk(rx_restart, 0, "R5 restart single");
    step(4);
  endtask

  // Positions (cycles after the rise) of the first two idle pulses in a window.
  task automatic idle_positions(input int win, output int p1, output int p2, output int cnt);
    p1 = -1; p2 = -1; cnt = 0;
    for (int j = 1; j <= win; j++) begin
      step(1);
      if (idle_pulse) begin
        cnt++;
        if (p1 < 0) p1 = j; else if (p2 < 0) p2 = j;
      end
    end
  endtask

  task automatic t_reset;
    step(3);
    chk(break_pulse, 0, "R11 break in reset");
    chk(idle_pulse, 0, "R11 idle in reset");
    chk(rx_restart, 0, "R11 restart in reset");
    rst = 1'b0;
    step(1);
    chk(break_pulse + idle_pulse + rx_restart, 0, "R11 outputs after release");
    step(5);
  endtask

  task automatic t_break_threshold;
    low_then_check(40, 1, "R2 low F=40");
    low_then_check(39, 0, "R3 low F-1=39");
    low_then_check(60, 1, "R2 low 60");
  endtask

  task automatic t_frame_formats;
    set_fmt(8, 1, 2, 3, 1);          // 12 bits * 3.0625 = 36.75 -> 37
    low_then_check(37, 1, "R1 F=37");
    low_then_check(36, 0, "R1 F-1=36");
    set_fmt(5, 0, 1, 6, 0);          // 7 bits * 6 = 42
    low_then_check(42, 1, "R1 F=42");
    low_then_check(41, 0, "R1 F-1=41");
    set_fmt(8, 0, 1, 4, 0);
  endtask

  task automatic t_split_low;
    rx_line = 1'b0; step(30);
    rx_line = 1'b1; step(2);
    rx_line = 1'b0; step(30);
    rx_line = 1'b1;
    for (int j = 1; j <= 6; j++) begin
      step(1);
      chk(break_pulse, 0, "R4 split low no break");
    end
  endtask

  task automatic t_idle;
    int p1, p2, cnt;
    rx_line = 1'b0; step(5);
    rx_line = 1'b1;
    idle_positions(2*40 + 5, p1, p2, cnt);
    chk(p1, 43, "R6 first idle");
    chk(p2, 83, "R6 second idle");
    chk(cnt, 2, "R6 idle count");
  endtask

  task automatic t_idle_glitch;
    int p1, p2, cnt;
    rx_line = 1'b0; step(5);
    rx_line = 1'b1; step(20);
    rx_line = 1'b0; step(1);
    rx_line = 1'b1;
    idle_positions(50, p1, p2, cnt);
    chk(p1, 43, "R7 idle restarts after low sample");
    chk(cnt, 1, "R7 idle count after glitch");
  endtask

  task automatic t_invert;
    cfg_invert = 1'b1; rx_line = 1'b0;
    step(10);
    low_then_check(0, 0, "R8 settle");
    rx_line = 1'b1; step(40);
    rx_line = 1'b0;
    step(3);
    chk(break_pulse, 1, "R8 inverted break");
    step(1);
    chk(break_pulse, 0, "R8 inverted break single");
    step(3);
    rx_line = 1'b1; step(39);
    rx_line = 1'b0;
    step(3);
    chk(break_pulse, 0, "R8 inverted short low");
    cfg_invert = 1'b0; rx_line = 1'b1;
    step(10);
  endtask

  task automatic t_cfg_hold;
    int p1, p2, cnt;
    rx_line = 1'b0; step(5);
    cfg_cpb = 8'd8;                  // F would become 80
    step(40);
    rx_line = 1'b1;
    step(3);
    chk(break_pulse, 1, "R9 old threshold kept during low");
    idle_positions(90, p1, p2, cnt);
    chk(p1, 80, "R9 new frame length after rise");
    cfg_cpb = 8'd4;
    step(6);
  endtask

  task automatic t_saturate;
    low_then_check(8200, 1, "R10 long low saturates");
  endtask

  initial begin
    t_reset();
    t_break_threshold();
    t_frame_formats();
    t_split_low();
    t_idle();
    t_idle_glitch();
    t_invert();
    t_cfg_hold();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule